// File: doc/BRIEF.md
# Battery-Monitor Chain Frame Codec with CRC-8

This block sits between a host-side sequencer and an SPI shifter that talks to a daisy chain of battery-monitor devices. On the transmit side it turns a write request into a 32-bit frame. The request carries a 5-bit device address, a 6-bit register address, a data byte and an all-parts flag. The codec computes the frame's 8-bit check code and sets a fixed 3-bit tail. It holds the frame on `tx_frame` for the shifter, which sends it most significant bit first. A separate request loads the fixed idle word. That word is a harmless write to device 0x1F with the all-parts flag clear, and it must be clocked out while readback data is being collected.

On the receive side the codec takes each 32-bit frame the shifter collects. It recomputes the check code over the upper 22 bits and compares it with the code carried in bits 9:2. When they differ it raises `crc_err` for one cycle. It also splits the frame into fields. In channel mode it extracts a device address, a 4-bit channel number and a 12-bit conversion result. In register mode it extracts the device address, a 6-bit register address and a data byte.

The check code uses the polynomial x^8+x^5+x^3+x^2+x+1 (0x2F). A table step T shifts a byte left eight times and XORs in 0x2F whenever a set bit falls out. For an input value V, the code is c1 = T(V[23:16]), then c2 = T(c1 XOR V[15:8]), and the result is c2 XOR V[7:0]. The last byte is folded in without a table step.

Top module: `chain_frame_codec`

## Requirements
- R1: After synchronous reset, `tx_frame` is 0xF800030A and `tx_valid`, `rx_done` and `crc_err` are 0. All read fields are 0.
- R2: One cycle after `wr_valid`, `tx_frame` holds the following fields: `wr_dev` in bits 31:27, `wr_reg` in bits 26:21, `wr_data` in bits 20:13, `wr_all` in bit 12, and 0 in bit 11.
- R3: For a write frame, bits 10:3 hold the check code of V = frame bits 31:11, taken as a 21-bit value. Bits 2:0 are 3'b010.
- R4: `tx_valid` is high for exactly the cycle after each cycle with `wr_valid` high. `tx_frame` changes only after `wr_valid` or `rd_idle`.
- R5: One cycle after `rd_idle` with `wr_valid` low, `tx_frame` is 0xF800030A. When both are high in the same cycle, the write request wins.
- R6: One cycle after `rx_valid`, `crc_err` is 1 exactly when the check code of `rx_frame` bits 31:10, taken as a 22-bit value, differs from `rx_frame` bits 9:2. Bits 1:0 take no part. `crc_err` is 0 in every other cycle.
- R7: With `rx_mode`=0 (channel), one cycle after `rx_valid` the outputs hold these fields: `rd_dev` = bits 31:27, `rd_chan` = bits 26:23, `rd_result` = bits 22:11.
- R8: With `rx_mode`=1 (register), one cycle after `rx_valid` the outputs hold these fields: `rd_dev` = bits 31:27, `rd_reg` = bits 26:21, `rd_byte` = bits 20:13.
- R9: A frame received in one mode leaves the other mode's field outputs unchanged. Fields are loaded even from a frame that fails the check.
- R10: `rx_done` is high for exactly the cycle after each cycle with `rx_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Build a write frame from the request this cycle |
| wr_dev | input | 5 | Target device address |
| wr_reg | input | 6 | Target register address |
| wr_data | input | 8 | Data byte to write |
| wr_all | input | 1 | All-parts flag |
| rd_idle | input | 1 | Load the idle transmit word |
| tx_frame | output | 32 | Frame presented to the shifter |
| tx_valid | output | 1 | A new write frame was loaded |
| rx_valid | input | 1 | A received frame is present |
| rx_frame | input | 32 | Received frame |
| rx_mode | input | 1 | 0: channel readback, 1: register readback |
| rx_done | output | 1 | Received frame decoded |
| crc_err | output | 1 | Received frame failed the check |
| rd_dev | output | 5 | Device address of the last frame |
| rd_chan | output | 4 | Channel of the last channel frame |
| rd_result | output | 12 | Result of the last channel frame |
| rd_reg | output | 6 | Register address of the last register frame |
| rd_byte | output | 8 | Data byte of the last register frame |

## Verification
The hardest case to reach from the ports is a received frame that passes the check: a random 32-bit word matches its own code only about once in 256. So the stimulus first builds each word's bits 31:10, computes the code independently, and places it in bits 9:2. It then randomises bits 1:0 to show they are ignored. From those valid frames it flips single bits, in the covered region and in the code field, to force mismatches. It also alternates the receive mode while fields are loaded, and it issues the write and idle requests in the same cycle.

// File: rtl/chain_codec_pkg.sv
package chain_codec_pkg;
    localparam int FRAME_W = 32;
    localparam int DEV_W   = 5;
    localparam int REG_W   = 6;
    localparam int BYTE_W  = 8;
    localparam int CHAN_W  = 4;
    localparam int RES_W   = 12;
    localparam int CRC_W   = 8;
    localparam int CRC_IN_W = 24;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h2F;
    localparam logic [2:0] WR_TAIL  = 3'b010;
    localparam logic [DEV_W-1:0] IDLE_DEV = 5'h1F;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [REG_W-1:0]  regaddr;
        logic [BYTE_W-1:0] data;
        logic              all;
    } wr_req_t;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [CHAN_W-1:0] chan;
        logic [RES_W-1:0]  result;
        logic [REG_W-1:0]  regaddr;
        logic [BYTE_W-1:0] rbyte;
    } rd_fields_t;

    // one table step: eight shifts, polynomial folded in on carry-out
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in);
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[CRC_W-1]) c = (c << 1) ^ CRC_POLY;
            else            c = c << 1;
        end
        return c;
    endfunction

    // two stepped bytes, last byte folded in raw
    function automatic logic [CRC_W-1:0] crc_code(input logic [CRC_IN_W-1:0] v);
        logic [CRC_W-1:0] c;
        c = crc_step(v[23:16]);
        c = crc_step(c ^ v[15:8]);
        return c ^ v[7:0];
    endfunction
endpackage

// File: rtl/codec_frame_builder.sv
module codec_frame_builder
    import chain_codec_pkg::*;
(
    input  wr_req_t              req,
    output logic [FRAME_W-1:0]   frame
);
    localparam int HEAD_W = DEV_W + REG_W + BYTE_W + 1;
    localparam int COVER_W = HEAD_W + 1;

    logic [HEAD_W-1:0]  head;
    logic [COVER_W-1:0] covered;
    logic [CRC_W-1:0]   code;

    always_comb begin
        head    = req;
        covered = {head, 1'b0};
        code    = crc_code({{(CRC_IN_W-COVER_W){1'b0}}, covered});
        frame   = {covered, code, WR_TAIL};
    end
endmodule

// File: rtl/codec_frame_checker.sv
module codec_frame_checker
    import chain_codec_pkg::*;
(
    input  logic [FRAME_W-1:0] frame,
    output logic               code_bad,
    output logic [DEV_W-1:0]   dev,
    output logic [CHAN_W-1:0]  chan,
    output logic [RES_W-1:0]   result,
    output logic [REG_W-1:0]   regaddr,
    output logic [BYTE_W-1:0]  rbyte
);
    localparam int COVER_W = FRAME_W - 10;

    logic [CRC_W-1:0] recomputed;

    always_comb begin
        recomputed = crc_code({{(CRC_IN_W-COVER_W){1'b0}}, frame[FRAME_W-1:10]});
        code_bad   = (recomputed != frame[9:2]);
        dev        = frame[31:27];
        chan       = frame[26:23];
        result     = frame[22:11];
        regaddr    = frame[26:21];
        rbyte      = frame[20:13];
    end
endmodule

// File: rtl/chain_frame_codec.sv
module chain_frame_codec
    import chain_codec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [4:0]         wr_dev,
    input  logic [5:0]         wr_reg,
    input  logic [7:0]         wr_data,
    input  logic               wr_all,
    input  logic               rd_idle,
    output logic [31:0]        tx_frame,
    output logic               tx_valid,
    input  logic               rx_valid,
    input  logic [31:0]        rx_frame,
    input  logic               rx_mode,
    output logic               rx_done,
    output logic               crc_err,
    output logic [4:0]         rd_dev,
    output logic [3:0]         rd_chan,
    output logic [11:0]        rd_result,
    output logic [5:0]         rd_reg,
    output logic [7:0]         rd_byte
);
    wr_req_t            req, idle_req;
    logic [FRAME_W-1:0] req_frame, idle_frame;
    logic               code_bad;
    rd_fields_t         dec, held;

    always_comb begin
        req      = '{dev: wr_dev, regaddr: wr_reg, data: wr_data, all: wr_all};
        idle_req = '{dev: IDLE_DEV, regaddr: '0, data: '0, all: 1'b0};
    end

    codec_frame_builder u_build (.req(req), .frame(req_frame));
    codec_frame_builder u_idle  (.req(idle_req), .frame(idle_frame));

    codec_frame_checker u_check (
        .frame   (rx_frame),
        .code_bad(code_bad),
        .dev     (dec.dev),
        .chan    (dec.chan),
        .result  (dec.result),
        .regaddr (dec.regaddr),
        .rbyte   (dec.rbyte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_frame <= idle_frame;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= wr_valid;
            if (wr_valid)     tx_frame <= req_frame;
            else if (rd_idle) tx_frame <= idle_frame;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            rx_done <= 1'b0;
            crc_err <= 1'b0;
        end else begin
            rx_done <= rx_valid;
            crc_err <= rx_valid && code_bad;
            if (rx_valid) begin
                held.dev <= dec.dev;
                if (rx_mode) begin
                    held.regaddr <= dec.regaddr;
                    held.rbyte   <= dec.rbyte;
                end else begin
                    held.chan    <= dec.chan;
                    held.result  <= dec.result;
                end
            end
        end
    end

    assign rd_dev    = held.dev;
    assign rd_chan   = held.chan;
    assign rd_result = held.result;
    assign rd_reg    = held.regaddr;
    assign rd_byte   = held.rbyte;
endmodule

// File: rtl/chain_frame_codec_checker.sv
module chain_frame_codec_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic        rd_idle,
    input logic [31:0] tx_frame,
    input logic        tx_valid,
    input logic        rx_valid,
    input logic        rx_mode,
    input logic        rx_done,
    input logic        crc_err,
    input logic [3:0]  rd_chan,
    input logic [11:0] rd_result,
    input logic [5:0]  rd_reg,
    input logic [7:0]  rd_byte
);
    // R3: every frame presented ends in the fixed tail
    p_tail_r3: assert property (@(posedge clk) disable iff (rst)
        tx_frame[2:0] == 3'b010);

    // R4: pulse follows request
    p_txv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> tx_valid);
    p_txv_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !tx_valid);
    p_tx_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid && !rd_idle) |=> $stable(tx_frame));

    // R10: done follows each received frame
    p_done_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rx_done);
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !rx_done);

    // R6: an error only accompanies a decoded frame
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> rx_done);

    // R9: a register frame leaves channel fields, and the reverse
    p_keep_chan_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_mode) |=> ($stable(rd_chan) && $stable(rd_result)));
    p_keep_reg_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_mode) |=> ($stable(rd_reg) && $stable(rd_byte)));
endmodule

bind chain_frame_codec chain_frame_codec_checker u_checker (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_idle(rd_idle),
    .tx_frame(tx_frame), .tx_valid(tx_valid), .rx_valid(rx_valid),
    .rx_mode(rx_mode), .rx_done(rx_done), .crc_err(crc_err),
    .rd_chan(rd_chan), .rd_result(rd_result), .rd_reg(rd_reg),
    .rd_byte(rd_byte)
);

// File: tb/chain_frame_codec_bench.sv
module chain_frame_codec_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 0, wr_all = 0, rd_idle = 0, rx_valid = 0, rx_mode = 0;
    logic [4:0]  wr_dev = 0;
    logic [5:0]  wr_reg = 0;
    logic [7:0]  wr_data = 0;
    logic [31:0] rx_frame = 0;
    logic [31:0] tx_frame;
    logic        tx_valid, rx_done, crc_err;
    logic [4:0]  rd_dev;
    logic [3:0]  rd_chan;
    logic [11:0] rd_result;
    logic [5:0]  rd_reg;
    logic [7:0]  rd_byte;

    int tests = 0, fails = 0;
    bit finished = 0;

    // reference state
    logic [31:0] m_tx;
    logic        m_txv, m_done, m_err;
    logic [4:0]  m_dev;
    logic [3:0]  m_chan;
    logic [11:0] m_res;
    logic [5:0]  m_reg;
    logic [7:0]  m_byte;

    always #10 clk = ~clk;

    chain_frame_codec u_chain_frame_codec (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_dev(wr_dev),
        .wr_reg(wr_reg), .wr_data(wr_data), .wr_all(wr_all),
        .rd_idle(rd_idle), .tx_frame(tx_frame), .tx_valid(tx_valid),
        .rx_valid(rx_valid), .rx_frame(rx_frame), .rx_mode(rx_mode),
        .rx_done(rx_done), .crc_err(crc_err), .rd_dev(rd_dev),
        .rd_chan(rd_chan), .rd_result(rd_result), .rd_reg(rd_reg),
        .rd_byte(rd_byte)
    );

    function automatic int tstep(int b);
        int c = b;
        for (int k = 0; k < 8; k++) begin
            c = c << 1;
            if (c & 256) c = (c ^ 'h2F) & 255;
        end
        return c;
    endfunction

    function automatic int code_of(int v);
        int c = tstep((v >> 16) & 255);
        c = tstep(c ^ ((v >> 8) & 255));
        return c ^ (v & 255);
    endfunction

    function automatic logic [31:0] wr_word(int d, int r, int x, int a);
        int v = (d << 16) | (r << 10) | (x << 2) | (a << 1);
        return (32'(v) << 11) | (32'(code_of(v)) << 3) | 32'd2;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 tx fields", {21'b0, tx_frame[31:21]} << 0, {21'b0, m_tx[31:21]});
        chk("R2 tx low fields", {12'b0, tx_frame[20:11]}, {12'b0, m_tx[20:11]});
        chk("R3 tx code and tail", {21'b0, tx_frame[10:0]}, {21'b0, m_tx[10:0]});
        chk("R4 tx_valid", {31'b0, tx_valid}, {31'b0, m_txv});
        chk("R10 rx_done", {31'b0, rx_done}, {31'b0, m_done});
        chk("R6 crc_err", {31'b0, crc_err}, {31'b0, m_err});
        chk("R7 rd_dev", {27'b0, rd_dev}, {27'b0, m_dev});
        chk("R7 rd_chan/R9", {28'b0, rd_chan}, {28'b0, m_chan});
        chk("R7 rd_result/R9", {20'b0, rd_result}, {20'b0, m_res});
        chk("R8 rd_reg/R9", {26'b0, rd_reg}, {26'b0, m_reg});
        chk("R8 rd_byte/R9", {24'b0, rd_byte}, {24'b0, m_byte});
    endtask

    // one clock: model updates from the inputs at the edge, compare at negedge
    task automatic cyc();
        @(posedge clk);
        if (rst) begin
            m_tx = 32'hF800030A; m_txv = 0; m_done = 0; m_err = 0;
            m_dev = 0; m_chan = 0; m_res = 0; m_reg = 0; m_byte = 0;
        end else begin
            m_txv = wr_valid;
            if (wr_valid) m_tx = wr_word(wr_dev, wr_reg, wr_data, wr_all);
            else if (rd_idle) m_tx = 32'hF800030A;
            m_done = rx_valid;
            m_err = rx_valid && (code_of(int'(rx_frame >> 10)) != int'(rx_frame[9:2]));
            if (rx_valid) begin
                m_dev = rx_frame[31:27];
                if (rx_mode) begin m_reg = rx_frame[26:21]; m_byte = rx_frame[20:13]; end
                else begin m_chan = rx_frame[26:23]; m_res = rx_frame[22:11]; end
            end
        end
        @(negedge clk);
        if (!rst) compare_all();
        wr_valid = 0; rd_idle = 0; rx_valid = 0;
    endtask

    function automatic logic [31:0] good_rx(logic [21:0] top, logic [1:0] lo);
        return {top, 8'(code_of(int'(top))), lo};
    endfunction

    task automatic send_wr(int d, int r, int x, int a);
        wr_valid = 1; wr_dev = 5'(d); wr_reg = 6'(r); wr_data = 8'(x); wr_all = a[0];
        cyc();
    endtask

    task automatic send_rx(logic [31:0] f, logic md);
        rx_valid = 1; rx_frame = f; rx_mode = md;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_frame", tx_frame, 32'hF800030A);
        chk("R1 flags", {29'b0, tx_valid, rx_done, crc_err}, 32'h0);
        chk("R1 fields", {rd_dev, rd_chan, rd_result, rd_reg, rd_byte}, 35'h0);

        // R2/R3 corner writes
        send_wr(0, 0, 0, 0);
        send_wr(31, 63, 255, 1);
        send_wr(5'h15, 6'h2A, 8'hA5, 0);
        send_wr(1, 1, 1, 1);
        cyc(); cyc();           // R4 hold
        // R5 idle load, and priority of write over idle
        rd_idle = 1; cyc();
        chk("R5 idle word", tx_frame, 32'hF800030A);
        wr_valid = 1; rd_idle = 1; wr_dev = 3; wr_reg = 4; wr_data = 5; wr_all = 1; cyc();
        chk("R5 write wins", tx_frame, wr_word(3, 4, 5, 1));
        send_wr(31, 0, 0, 0);
        chk("R3 idle equals built write", tx_frame, 32'hF800030A);

        // R6/R7/R8 valid and corrupted frames
        send_rx(good_rx(22'h3FFFFF, 2'b11), 0);
        send_rx(good_rx(22'h000000, 2'b00), 1);
        send_rx(good_rx(22'h2AAAAA, 2'b01), 0);
        send_rx(good_rx(22'h155555, 2'b10), 1);
        for (int b = 0; b < 32; b++) begin
            logic [31:0] f = good_rx(22'h12D3A7, 2'b00) ^ (32'd1 << b);
            send_rx(f, b[0]);
        end
        // back-to-back mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] f = good_rx(22'($urandom), 2'($urandom));
            if ($urandom_range(0, 3) == 0) f ^= 32'd1 << $urandom_range(0, 31);
            wr_valid = ($urandom_range(0, 2) == 0);
            wr_dev = 5'($urandom); wr_reg = 6'($urandom);
            wr_data = 8'($urandom); wr_all = 1'($urandom);
            rd_idle = ($urandom_range(0, 4) == 0);
            rx_valid = ($urandom_range(0, 1) == 0);
            rx_frame = f; rx_mode = 1'($urandom);
            cyc();
        end
        // R9 explicit: register frame must not touch channel fields
        send_rx(good_rx({5'd7, 4'h9, 12'hABC, 1'b0}, 2'b00), 0);
        send_rx(good_rx({5'd8, 6'h3F, 8'h11, 3'b0}, 2'b00), 1);
        chk("R9 channel kept", {20'b0, rd_result}, 32'hABC);
        cyc();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule